// File: doc/BRIEF.md
# Dual-Port Four-Word Burst Sequencer

This block drives the address and strobe sequence for a synchronous memory that has separate read and write ports. Each access is a burst of four words, and two words move on each control clock. A port starts a burst when its active-low select is sampled low on a rising edge and the port is free. The word address sampled on that edge becomes the burst base. Two low-order bits are appended to form sub-addresses. The first clock of the burst carries sub-offsets 0 and 1, and the second clock carries offsets 2 and 3. The order is always linear.

The read and write engines run independently, and their bursts may overlap in time. Only one of the two may begin on any given edge. When both selects are low and both ports are free, the read burst begins and the write request on that edge is dropped. A port that is in the second clock of its burst can accept a new select on that same edge, so consecutive bursts follow each other with no gap. A select sampled during the first clock of a burst has no effect and is not remembered. The read port also raises a one-clock flag in the first clock of each read burst.

Reset is asynchronous and active low. The block releases it internally in step with the clock through a two-stage synchronizer.

Top module: `qburst_seq`

## Requirements
- R1: While reset is active, and after it is released with both selects high, both ports report busy low, both valid strobes low, read-initial flag low and word outputs zero.
- R2: A port that is idle and samples its select low starts a burst. In the next clock it reports busy, both strobes high, low-half word {base,2'b00} and high-half word {base,2'b01}, where base is the address sampled with the select.
- R3: In the clock after the first burst clock, the port keeps busy and both strobes high, and outputs {base,2'b10} and {base,2'b11} with the same base.
- R4: A select sampled low on the edge that ends the second burst clock starts a new burst with the newly sampled address in the very next clock, with no idle clock between the bursts.
- R5: If the select is high on the edge that ends the second burst clock, the port is idle in the next clock: busy and strobes low, words zero.
- R6: A select or address presented on the edge that ends the first burst clock is ignored and is not queued. The burst continues with the original base, and that select does not start a burst later.
- R7: Read and write bursts may be active in the same clock, each with its own base and offsets.
- R8: When both selects are sampled low on an edge where both ports could start, only the read burst starts. The write port does not start on that edge.
- R9: The read-initial flag is high exactly in the first clock of each read burst and low in every other clock.
- R10: Both ports follow R2 to R6 identically. The write port has no initial flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_k | input | 1 | Control clock; all state changes on its rising edge |
| arst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read select, active low |
| wr_sel_n | input | 1 | Write select, active low |
| rd_addr | input | ADDR_W | Read burst base address |
| wr_addr | input | ADDR_W | Write burst base address |
| rd_busy | output | 1 | Read burst in progress |
| rd_init | output | 1 | First clock of a read burst |
| rd_vld_lo | output | 1 | Read word valid, first half-cycle |
| rd_vld_hi | output | 1 | Read word valid, second half-cycle |
| rd_word_lo | output | ADDR_W+2 | Read sub-address, first half-cycle |
| rd_word_hi | output | ADDR_W+2 | Read sub-address, second half-cycle |
| wr_busy | output | 1 | Write burst in progress |
| wr_vld_lo | output | 1 | Write word valid, first half-cycle |
| wr_vld_hi | output | 1 | Write word valid, second half-cycle |
| wr_word_lo | output | ADDR_W+2 | Write sub-address, first half-cycle |
| wr_word_hi | output | ADDR_W+2 | Write sub-address, second half-cycle |

## Verification
The first directed pattern is an isolated single burst. It separates the first-clock offsets from the second-clock offsets and shows the return to idle. A select held low across several clocks, with the address changing every clock, shows which edges load a new base and which are ignored. Both selects driven low together from idle, and again while one port is mid-burst, show how read priority differs from ordinary overlap. A long pseudo-random run of both selects and addresses then exercises arbitrary interleavings against the reference model, with outputs compared on every clock.

// File: rtl/qb_pkg.sv
package qb_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_FIRST  = 2'd1,
    PS_SECOND = 2'd2
  } port_state_t;

  localparam int unsigned SUB_W = 2;
endpackage

// File: rtl/qb_rst_sync.sv
module qb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/qb_arbiter.sv
module qb_arbiter (
  input  logic rd_sel_n,
  input  logic wr_sel_n,
  input  logic rd_ready,
  input  logic wr_ready,
  output logic rd_go,
  output logic wr_go
);
  always_comb begin
    rd_go = !rd_sel_n && rd_ready;
    wr_go = !wr_sel_n && wr_ready && !rd_go;
  end
endmodule

// File: rtl/qb_port_engine.sv
module qb_port_engine
  import qb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned WORD_W = ADDR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              first_o,
  output logic              busy_o,
  output logic              vld_lo_o,
  output logic              vld_hi_o,
  output logic [WORD_W-1:0] word_lo_o,
  output logic [WORD_W-1:0] word_hi_o
);
  port_state_t       state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              base_en;

  always_comb begin
    state_d = state_q;
    base_en = 1'b0;
    unique case (state_q)
      PS_IDLE: if (go_i) begin
        state_d = PS_FIRST;
        base_en = 1'b1;
      end
      PS_FIRST: state_d = PS_SECOND;
      PS_SECOND: begin
        if (go_i) begin
          state_d = PS_FIRST;
          base_en = 1'b1;
        end else begin
          state_d = PS_IDLE;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= addr_i;
  end

  logic active, second;
  always_comb begin
    active    = (state_q != PS_IDLE);
    second    = (state_q == PS_SECOND);
    ready_o   = (state_q != PS_FIRST);
    first_o   = (state_q == PS_FIRST);
    busy_o    = active;
    vld_lo_o  = active;
    vld_hi_o  = active;
    word_lo_o = active ? {base_q, second, 1'b0} : '0;
    word_hi_o = active ? {base_q, second, 1'b1} : '0;
  end

  // R3: the first burst clock always moves to the second with the same base
  a_r3_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_FIRST) |=> (state_q == PS_SECOND) && $stable(base_q));

  // R4: a start at the end of the second clock reloads the base with no gap
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SECOND && go_i) |=> (state_q == PS_FIRST) && (base_q == $past(addr_i)));

  // R5: no start at the end of the second clock returns to idle
  a_r5_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SECOND && !go_i) |=> (state_q == PS_IDLE));

  // R6: a request during the first clock leaves the base untouched
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_FIRST && go_i) |=> (base_q == $past(base_q)));
endmodule

// File: rtl/qburst_seq.sv
module qburst_seq
  import qb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned WORD_W = ADDR_W + SUB_W
) (
  input  logic              clk_k,
  input  logic              arst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              rd_busy,
  output logic              rd_init,
  output logic              rd_vld_lo,
  output logic              rd_vld_hi,
  output logic [WORD_W-1:0] rd_word_lo,
  output logic [WORD_W-1:0] rd_word_hi,
  output logic              wr_busy,
  output logic              wr_vld_lo,
  output logic              wr_vld_hi,
  output logic [WORD_W-1:0] wr_word_lo,
  output logic [WORD_W-1:0] wr_word_hi
);
  logic rst_n;
  logic rd_ready, wr_ready, rd_go, wr_go, wr_first;

  qb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_k), .arst_n(arst_n), .rst_n(rst_n)
  );

  qb_arbiter u_arb (
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_ready(rd_ready), .wr_ready(wr_ready),
    .rd_go(rd_go), .wr_go(wr_go)
  );

  qb_port_engine #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk_k), .rst_n(rst_n), .go_i(rd_go), .addr_i(rd_addr),
    .ready_o(rd_ready), .first_o(rd_init), .busy_o(rd_busy),
    .vld_lo_o(rd_vld_lo), .vld_hi_o(rd_vld_hi),
    .word_lo_o(rd_word_lo), .word_hi_o(rd_word_hi)
  );

  qb_port_engine #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk_k), .rst_n(rst_n), .go_i(wr_go), .addr_i(wr_addr),
    .ready_o(wr_ready), .first_o(wr_first), .busy_o(wr_busy),
    .vld_lo_o(wr_vld_lo), .vld_hi_o(wr_vld_hi),
    .word_lo_o(wr_word_lo), .word_hi_o(wr_word_hi)
  );

  // R8: both free and both selected -> only the read burst opens
  a_r8_read_wins: assert property (@(posedge clk_k) disable iff (!rst_n)
    (!rd_sel_n && !wr_sel_n && !rd_init && !wr_first) |=> (rd_init && !wr_first));

  // R9: the initial flag lasts one clock
  a_r9_init_pulse: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_init |=> !rd_init);
endmodule

// File: tb/qburst_seq_tb_top.sv
module qburst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int WW = AW + 2;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic rd_busy, rd_init, rd_vld_lo, rd_vld_hi, wr_busy, wr_vld_lo, wr_vld_hi;
  logic [WW-1:0] rd_word_lo, rd_word_hi, wr_word_lo, wr_word_hi;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // model: count -1 idle, 0 first clock, 2 second clock
  int r_cnt = -1, w_cnt = -1;
  int r_base = 0, w_base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qburst_seq #(.ADDR_W(AW)) dut_i (
    .clk_k(clk), .arst_n(arst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_addr(rd_addr), .wr_addr(wr_addr),
    .rd_busy(rd_busy), .rd_init(rd_init), .rd_vld_lo(rd_vld_lo), .rd_vld_hi(rd_vld_hi),
    .rd_word_lo(rd_word_lo), .rd_word_hi(rd_word_hi),
    .wr_busy(wr_busy), .wr_vld_lo(wr_vld_lo), .wr_vld_hi(wr_vld_hi),
    .wr_word_lo(wr_word_lo), .wr_word_hi(wr_word_hi)
  );

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int rl, wl;
    rl = (r_cnt >= 0) ? r_base * 4 + r_cnt : 0;
    wl = (w_cnt >= 0) ? w_base * 4 + w_cnt : 0;
    chk("rd_busy", rd_busy, r_cnt >= 0);
    chk("rd_vld", {rd_vld_lo, rd_vld_hi}, (r_cnt >= 0) ? 3 : 0);
    chk("rd_init", rd_init, r_cnt == 0);
    chk("rd_word_lo", rd_word_lo, rl);
    chk("rd_word_hi", rd_word_hi, (r_cnt >= 0) ? rl + 1 : 0);
    chk("wr_busy", wr_busy, w_cnt >= 0);
    chk("wr_vld", {wr_vld_lo, wr_vld_hi}, (w_cnt >= 0) ? 3 : 0);
    chk("wr_word_lo", wr_word_lo, wl);
    chk("wr_word_hi", wr_word_hi, (w_cnt >= 0) ? wl + 1 : 0);
  endtask

  // one clock: drive at falling edge, update model at rising edge, compare after it
  task automatic cyc(bit rs, bit ws, int ra, int wa);
    bit rgo, wgo;
    @(negedge clk);
    rd_sel_n = rs; wr_sel_n = ws;
    rd_addr = AW'(ra); wr_addr = AW'(wa);
    @(posedge clk);
    rgo = !rs && (r_cnt != 0);
    wgo = !ws && (w_cnt != 0) && !rgo;
    if (rgo) begin r_cnt = 0; r_base = ra & 16'hFFFF; end
    else if (r_cnt == 0) r_cnt = 2;
    else r_cnt = -1;
    if (wgo) begin w_cnt = 0; w_base = wa & 16'hFFFF; end
    else if (w_cnt == 0) w_cnt = 2;
    else w_cnt = -1;
    #1;
    compare();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    #3;
    compare();
    repeat (3) @(posedge clk);
    #1 compare();
    @(negedge clk) arst_n = 1'b1;
    repeat (4) cyc(1, 1, 0, 0);

    // R2 / R3 / R5: single read burst
    cur_req = "R2";
    cyc(0, 1, 16'h0123, 0);
    cur_req = "R3";
    cyc(1, 1, 0, 0);
    cur_req = "R5";
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);

    // R10: single write burst
    cur_req = "R10";
    cyc(1, 0, 0, 16'hBEEF);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);

    // R4 / R6: read select held low with a changing address
    cur_req = "R4";
    for (int i = 0; i < 7; i++) cyc(0, 1, 16'h1000 + i, 0);
    cur_req = "R6";
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    // R6: request during first clock only, then released
    cyc(0, 1, 16'h0AAA, 0);
    cyc(0, 1, 16'h0BBB, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);

    // R10 / R4: write back-to-back
    cur_req = "R10";
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 16'h2200 + i);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);

    // R7: overlapping bursts
    cur_req = "R7";
    cyc(1, 0, 0, 16'h3333);
    cyc(0, 1, 16'h4444, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);

    // R8: both from idle, write held low afterwards
    cur_req = "R8";
    cyc(0, 0, 16'h0555, 16'h0666);
    cyc(1, 0, 0, 16'h0777);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);

    // R9 and all requirements: pseudo-random traffic
    cur_req = "R9";
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 2) == 0 ? 1'b1 : 1'b0, $urandom_range(0, 1) == 1,
          int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule